// File: doc/BRIEF.md
# Gated Multi-Mode Counter/Timer

A single counter/timer channel built from a low count byte and a high count byte. It runs in one of three counting arrangements: a 13-bit counter that uses 5 bits of the low byte under the full high byte, a plain 16-bit counter, and an 8-bit counter in the low byte that refills itself from the high byte each time it rolls over. A fourth mode code stops counting.

Each increment comes from one of two sources. The first is an internal clock-enable tick. The second is a rising edge on an external count pin, which passes through a synchronizer first. Counting takes place only while the run bit is set. When gate qualification is enabled, counting also needs an external gate pin, after a polarity choice, to read active. A rollover sets a sticky overflow flag, and that flag drives an interrupt request when the interrupt enable is set.

Software reaches the block through a small byte-wide register port. Address 0 holds the low count byte, address 1 the high count byte, and address 2 the control byte. Reads are combinational.

Top module: `gct_top`

## Requirements
- R1: After reset, the low byte, high byte and control byte all read 0x00 and `irq_o` is low.
- R2: In mode 0 (13-bit), the count is {high byte, low[4:0]}. Bits 7:5 of the low byte never change by counting. A step from high=0xFF and low[4:0]=0x1F clears both and sets the flag.
- R3: In mode 1 (16-bit), the count is {high, low}. A step from 0xFFFF wraps to 0x0000 and sets the flag.
- R4: In mode 2 (reload), a step from low=0xFF loads the low byte from the high byte and sets the flag. Any other step increments the low byte. Counting never changes the high byte.
- R5: No increment occurs while the run bit (control bit 5) is 0.
- R6: When the gate-mode bit (control bit 3) is 1, counting needs (synchronized gate pin XOR polarity bit 4) = 1. When bit 3 is 0, the gate pin has no effect.
- R7: Control bit 2 selects the source. At 0, each cycle with `tick_i` high is one step. At 1, each rising edge of the synchronized count pin is one step and `tick_i` is ignored.
- R8: `irq_o` is high exactly when the flag (control bit 7) and the interrupt enable (control bit 6) are both 1.
- R9: The flag stays set until a write to the control byte puts 0 in bit 7. A hardware overflow in the same cycle takes priority.
- R10: Mode 3 holds the count unchanged.
- R11: Writes at addresses 0, 1 and 2 update the addressed byte, and control bits 6:0 read back as written. A write to either count byte drops that cycle's step. Address 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal count enable, one step per high cycle |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| gate_pin_i | input | 1 | External gate pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that software never writes a count byte in the same cycle it expects a step to land. They also assume that the mode field stays fixed across a checked increment. The stimulus changes the mode, the gate pin and the source only while `tick_i` is low and the count pin is idle. It then waits out the synchronizer depth before it issues any step. Random runs preload values close to rollover so that the wrap and reload paths come up often.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PRE_W  = 5;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [1:0] {
    MODE_13  = 2'd0,
    MODE_16  = 2'd1,
    MODE_RLD = 2'd2,
    MODE_OFF = 2'd3
  } gct_mode_e;

  typedef struct packed {
    logic      irq_en;
    logic      run;
    logic      gate_pol;
    logic      gate_mode;
    logic      ext_src;
    gct_mode_e mode;
  } gct_ctrl_t;

  localparam int unsigned CTRL_W = $bits(gct_ctrl_t);
endpackage

// File: rtl/gct_sync.sv
module gct_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gct_step.sv
module gct_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic gate_mode_i,
  input  logic gate_pol_i,
  input  logic gate_s_i,
  input  logic ext_src_i,
  input  logic tick_i,
  input  logic cnt_s_i,
  output logic inc_o
);
  logic cnt_q;
  logic ext_edge;
  logic src_hit;
  logic gate_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 1'b0;
    else         cnt_q <= cnt_s_i;
  end

  assign ext_edge = cnt_s_i & ~cnt_q;
  assign src_hit  = ext_src_i ? ext_edge : tick_i;
  assign gate_ok  = ~gate_mode_i | (gate_s_i ^ gate_pol_i);
  assign inc_o    = run_i & gate_ok & src_hit;

  // external source: two steps never on back-to-back cycles (one per edge)
  p_one_per_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_src_i && inc_o) |=> !(ext_src_i && inc_o));
endmodule

// File: rtl/gct_core.sv
module gct_core
  import gct_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned PW = PRE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  gct_mode_e     mode_i,
  input  logic          inc_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_flag_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          flag_o
);
  localparam int unsigned CW = 2 * BW;
  localparam logic [BW-1:0] ONE_B = 1;
  localparam logic [PW-1:0] ONE_P = 1;
  localparam logic [CW-1:0] ONE_W = 1;

  logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic          flag_q, flag_n;
  logic          step, wrap;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    wrap = 1'b0;
    step = inc_i & ~wr_lo_i & ~wr_hi_i;
    if (step) begin
      unique case (mode_i)
        MODE_13: begin
          if (&lo_q[PW-1:0]) begin
            lo_n[PW-1:0] = '0;
            hi_n         = hi_q + ONE_B;
            wrap         = &hi_q;
          end else begin
            lo_n[PW-1:0] = lo_q[PW-1:0] + ONE_P;
          end
        end
        MODE_16: begin
          {hi_n, lo_n} = {hi_q, lo_q} + ONE_W;
          wrap         = &{hi_q, lo_q};
        end
        MODE_RLD: begin
          if (&lo_q) begin
            lo_n = hi_q;
            wrap = 1'b1;
          end else begin
            lo_n = lo_q + ONE_B;
          end
        end
        default: ;
      endcase
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
    // hardware set beats software clear
    if (wrap)           flag_n = 1'b1;
    else if (wr_flag_i) flag_n = wdata_i[BW-1];
    else                flag_n = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      flag_q <= flag_n;
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign flag_o = flag_q;

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));

  p_upper_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_13 && !wr_lo_i) |=> (lo_q[BW-1:PW] == $past(lo_q[BW-1:PW])));

  p_wrap16_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_16 && inc_i && !wr_lo_i && !wr_hi_i && (&{hi_q, lo_q}))
    |=> (lo_q == '0 && hi_q == '0 && flag_q));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RLD && inc_i && !wr_lo_i && !wr_hi_i && (&lo_q))
    |=> (lo_q == $past(hi_q) && flag_q));

  p_reload_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RLD && !wr_hi_i) |=> $stable(hi_q));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !wr_flag_i) |=> flag_q);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/gct_top.sv
module gct_top
  import gct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              gate_pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  gct_ctrl_t     ctrl_q;
  logic          wr_lo, wr_hi, wr_ctrl;
  logic [1:0]    pins_s;
  logic          inc;
  logic [BYTE_W-1:0] lo, hi;
  logic          flag;

  assign wr_lo   = wr_en_i && (addr_i == ADDR_LO);
  assign wr_hi   = wr_en_i && (addr_i == ADDR_HI);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= gct_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  gct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({gate_pin_i, cnt_pin_i}),
    .q_o   (pins_s)
  );

  gct_step u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.run),
    .gate_mode_i(ctrl_q.gate_mode),
    .gate_pol_i (ctrl_q.gate_pol),
    .gate_s_i   (pins_s[1]),
    .ext_src_i  (ctrl_q.ext_src),
    .tick_i     (tick_i),
    .cnt_s_i    (pins_s[0]),
    .inc_o      (inc)
  );

  gct_core #(.BW(BYTE_W), .PW(PRE_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (ctrl_q.mode),
    .inc_i    (inc),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wr_flag_i(wr_ctrl),
    .wdata_i  (wdata_i),
    .lo_o     (lo),
    .hi_o     (hi),
    .flag_o   (flag)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_LO:   rdata_o = lo;
      ADDR_HI:   rdata_o = hi;
      ADDR_CTRL: rdata_o = {flag, ctrl_q};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctrl_q.irq_en;

  p_run_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: tb/gct_top_tb_top.sv
module gct_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       cnt_pin_i = 1'b0;
  logic       gate_pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  gct_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .gate_pin_i(gate_pin_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); cnt_pin_i = 1'b1;
      repeat (3) @(negedge clk_i);
      cnt_pin_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic expect3(input string req, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] ct);
    logic [7:0] v;
    rd(2'd0, v); check(req, v, lo);
    rd(2'd1, v); check(req, v, hi);
    rd(2'd2, v); check(req, v, ct);
  endtask

  // reference step: returns {flag, hi, lo}
  function automatic logic [16:0] mstep(input logic [1:0] m, input logic [16:0] s);
    logic [7:0] lo, hi;
    logic       f;
    lo = s[7:0]; hi = s[15:8]; f = s[16];
    case (m)
      2'd0: begin
        if (lo[4:0] == 5'h1F) begin
          lo[4:0] = 5'h00;
          if (hi == 8'hFF) f = 1'b1;
          hi = hi + 8'd1;
        end else lo[4:0] = lo[4:0] + 5'd1;
      end
      2'd1: begin
        if ({hi, lo} == 16'hFFFF) f = 1'b1;
        {hi, lo} = {hi, lo} + 16'd1;
      end
      2'd2: begin
        if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
        else lo = lo + 8'd1;
      end
      default: ;
    endcase
    return {f, hi, lo};
  endfunction

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [16:0] st;
    logic [1:0]  m;
    int          n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    expect3("R1", 8'h00, 8'h00, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // R11 control readback and unused address
    wr(2'd2, 8'h5D);
    rd(2'd2, v); check("R11 ctrl", v, 8'h5D);
    wr(2'd3, 8'hAA);
    rd(2'd3, v); check("R11 addr3", v, 8'h00);
    wr(2'd2, 8'h00);

    // R3 16-bit wrap
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF); wr(2'd2, 8'h21);
    ticks(3);
    expect3("R3", 8'h01, 8'h00, 8'hA1);
    check("R8 irq off", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'hE1);
    #1 check("R8 irq on", {7'd0, irq_o}, 8'h01);
    ticks(2);
    rd(2'd2, v); check("R9 sticky", v, 8'hE1);
    wr(2'd2, 8'h61);
    rd(2'd2, v); check("R9 clear", v, 8'h61);
    check("R8 irq cleared", {7'd0, irq_o}, 8'h00);

    // R2 13-bit carry, upper low bits kept
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFE); wr(2'd1, 8'h00); wr(2'd2, 8'h20);
    ticks(3);
    expect3("R2 carry", 8'hE1, 8'h01, 8'h20);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hBF); wr(2'd1, 8'hFF); wr(2'd2, 8'h20);
    ticks(1);
    expect3("R2 wrap", 8'hA0, 8'h00, 8'hA0);

    // R4 reload
    wr(2'd2, 8'h02);
    wr(2'd0, 8'hFE); wr(2'd1, 8'h80); wr(2'd2, 8'h22);
    ticks(3);
    expect3("R4", 8'h81, 8'h80, 8'hA2);

    // R5 run clear
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    ticks(3);
    rd(2'd0, v); check("R5 stopped", v, 8'h10);

    // R6 gate polarity
    wr(2'd0, 8'h00);
    gate_pin_i = 1'b0; wr(2'd2, 8'h29); settle();
    ticks(4);
    rd(2'd0, v); check("R6 gate low pol0", v, 8'h00);
    gate_pin_i = 1'b1; settle();
    ticks(4);
    rd(2'd0, v); check("R6 gate high pol0", v, 8'h04);
    wr(2'd2, 8'h39); settle();
    ticks(3);
    rd(2'd0, v); check("R6 gate high pol1", v, 8'h04);
    gate_pin_i = 1'b0; settle();
    ticks(2);
    rd(2'd0, v); check("R6 gate low pol1", v, 8'h06);
    wr(2'd2, 8'h21); gate_pin_i = 1'b1; settle();
    ticks(1);
    rd(2'd0, v); check("R6 gate unused", v, 8'h07);
    gate_pin_i = 1'b0;

    // R7 external edges
    wr(2'd2, 8'h05); wr(2'd0, 8'h00); wr(2'd2, 8'h25); settle();
    pulses(5);
    rd(2'd0, v); check("R7 edges", v, 8'h05);
    ticks(4);
    rd(2'd0, v); check("R7 tick ignored", v, 8'h05);

    // R10 mode 3 holds
    wr(2'd2, 8'h03); wr(2'd0, 8'h12); wr(2'd2, 8'h23);
    ticks(3);
    rd(2'd0, v); check("R10 hold", v, 8'h12);

    // random runs against reference model (R2 R3 R4)
    for (int it = 0; it < 150; it++) begin
      m = 2'($urandom_range(0, 2));
      st[7:0]  = 8'($urandom);
      st[15:8] = 8'($urandom);
      st[16]   = 1'b0;
      if ($urandom_range(0, 1) == 1) begin
        st[15:8] = (m == 2'd2) ? st[15:8] : 8'hFF;
        st[7:0]  = 8'hFF - 8'($urandom_range(0, 6));
      end
      n = $urandom_range(1, 30);
      wr(2'd2, {6'd0, m});
      wr(2'd0, st[7:0]); wr(2'd1, st[15:8]);
      wr(2'd2, {6'b001000, m});
      ticks(n);
      for (int k = 0; k < n; k++) st = mstep(m, st);
      expect3(m == 2'd0 ? "R2 rand" : (m == 2'd1 ? "R3 rand" : "R4 rand"),
              st[7:0], st[15:8], {st[16], 5'b01000, m});
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule